// File: doc/BRIEF.md
# PCI-to-PCI Bridge Header Register File

This block holds the bridge-specific part of a type-1 configuration header. A configuration agent writes whole dwords with per-byte enables and reads whole dwords back one cycle after asking. Each field applies its own rules. Fields that software may change take the written bytes. Read-only fields return fixed identity and capability values. Bits that software may not write keep their value whatever is written.

A downstream window decoder reads the command enables, the bridge control word and the forwarding windows directly from the output ports. The windows are the I/O, memory and prefetchable base/limit pairs, already widened to full byte addresses. The block also issues a single-cycle reset pulse for the secondary bus.

Synchronous reset comes in two flavours, picked by a pin sampled while reset is held. The normal flavour zeroes every window, so the window decoder sees empty ranges. The forwarding-off flavour loads every base with all ones and every limit with zeros, so each window has its base above its limit.

Top module: `p2p_hdr_regs`

## Requirements
- R1: While `rst` is high with `rst_fwd_off` low, the following are cleared to zero on the next clock edge: the bus-number dword (0x18: primary, secondary, subordinate, secondary latency), all base/limit address bits, the upper registers (0x28, 0x2C, 0x30), the command word and bridge control. After this reset, `mem_base`=0, `mem_limit`=0x000FFFFF and `io_limit`=0x00000FFF.
- R2: While `rst` is high with `rst_fwd_off` high, the address bits of each base are set to ones and those of each limit are cleared, with the upper registers at zero. This gives `io_base`=0x0000F000, `mem_base`=0xFFF00000 and `pf_base`=0x00000000FFF00000, and each limit holds only its fixed low ones.
- R3: On a write, byte lane i (bits 8i+7..8i) changes only when `be[i]` is 1. Unselected lanes keep their value.
- R4: The following fields read as constants and ignore writes:
  - dword 0x04 [31:16] (status) and dword 0x1C [31:16] (secondary status) read 0x00A0 (bit 5 = 66 MHz, bit 7 = fast back-to-back).
  - dword 0x08 reads {24'h060400, REV}.
  - dword 0x0C [23:16] reads {MULTI_FN, 7'h01}.
  - the low nibbles of the I/O base (0x1C [3:0]) and I/O limit (0x1C [11:8]) read 1 when IO32 is set.
  - the low nibbles of the prefetchable base (0x24 [3:0]) and limit (0x24 [19:16]) read 1 when PF64 is set.
  - the memory base/limit low nibbles read 0.
- R5: The window ports are built from the register fields as follows:
  - `io_base` = {I/O base upper16 (0x30 [15:0]), 0x1C [7:4], 12'h000}; `io_limit` = {0x30 [31:16], 0x1C [15:12], 12'hFFF}.
  - `mem_base` = {0x20 [15:4], 20'h0}; `mem_limit` = {0x20 [31:20], 20'hFFFFF}.
  - `pf_base` = {0x28, 0x24 [15:4], 20'h0}; `pf_limit` = {0x2C, 0x24 [31:20], 20'hFFFFF}.
- R6: With IO32 set, dword 0x30 is fully writable and feeds bits 31:16 of the I/O window. With PF64 set, dwords 0x28 and 0x2C are fully writable and feed bits 63:32 of the prefetchable window. With either option clear, the matching registers read zero.
- R7: `sec_bus_rst` is high for exactly one cycle, the cycle after a write that takes bridge-control bit 6 (dword 0x3C bit 22) from 0 to 1. Writing 1 while the bit is already 1, or masking lane 2, gives no pulse.
- R8: While `sec_express` is 1 and SLT_WRITABLE is 0, the secondary latency byte (0x18 [31:24]) reads zero and ignores writes. Otherwise it is writable.
- R9: A read returns its dword on `rdata` with `rd_valid` high exactly one cycle after `rd_en`. Dword indices with no register read zero and ignore writes.
- R10: In the command word, bits 0, 1, 2, 6, 8 and 10 are writable and the rest read 0. In bridge control, bits 6:0 are writable. `cmd_io_en` follows command bit 0, `cmd_mem_en` follows command bit 1, and `bridge_ctl` shows bridge control, with bit 3 being the VGA enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_fwd_off | input | 1 | Reset flavour: 1 leaves forwarding disabled |
| sec_express | input | 1 | Secondary side is an express link |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Dword index (byte offset / 4) |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables |
| rdata | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid |
| cmd_io_en | output | 1 | I/O space enable |
| cmd_mem_en | output | 1 | Memory space enable |
| bridge_ctl | output | 16 | Bridge control word |
| io_base | output | 32 | I/O window base |
| io_limit | output | 32 | I/O window limit |
| mem_base | output | 32 | Memory window base |
| mem_limit | output | 32 | Memory window limit |
| pf_base | output | 64 | Prefetchable window base |
| pf_limit | output | 64 | Prefetchable window limit |
| sec_bus_rst | output | 1 | One-cycle secondary bus reset pulse |

## Verification
The hardest situation to reach is a secondary-reset pulse that must not appear. Two cases matter: a write of bit 6 that is already set, and a write whose data sets bit 6 while byte lane 2 is masked. The directed part builds both from a known bit state. The random part writes bridge control often with random enables, so that rising edges, repeated ones and masked lanes occur in many orders. The forwarding-off reset and the express latency lock are also entered on purpose, and random writes and reads are then issued on top of them.

// File: rtl/p2p_hdr_pkg.sv
`timescale 1ns/1ps
package p2p_hdr_pkg;
  localparam int DW_BITS = 32;
  localparam int LANES   = DW_BITS / 8;

  // Dword indices within the header (byte offset / 4)
  localparam int IX_CMD   = 1;
  localparam int IX_CLASS = 2;
  localparam int IX_HDR   = 3;
  localparam int IX_BUS   = 6;
  localparam int IX_IOSEC = 7;
  localparam int IX_MEM   = 8;
  localparam int IX_PF    = 9;
  localparam int IX_PFBU  = 10;
  localparam int IX_PFLU  = 11;
  localparam int IX_IOU   = 12;
  localparam int IX_BCTL  = 15;

  localparam logic [15:0] STAT_CAPS = 16'h00A0;   // 66 MHz + fast back-to-back
  localparam logic [23:0] CLASS_P2P = 24'h060400;
  localparam int          SBR_BIT   = 6;

  // Merge write data into a stored dword: only enabled lanes, only writable bits.
  function automatic logic [DW_BITS-1:0] lane_merge(
      input logic [DW_BITS-1:0] cur,
      input logic [DW_BITS-1:0] nxt,
      input logic [LANES-1:0]   be,
      input logic [DW_BITS-1:0] wmask);
    logic [DW_BITS-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = be[i] ? 8'hFF : 8'h00;
    m = m & wmask;
    return (cur & ~m) | (nxt & m);
  endfunction
endpackage

// File: rtl/p2p_bus_regs.sv
`timescale 1ns/1ps
module p2p_bus_regs
  import p2p_hdr_pkg::*;
#(
  parameter bit SLT_WRITABLE = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_express,
  input  logic               we,
  input  logic [DW_BITS-1:0] wdata,
  input  logic [LANES-1:0]   be,
  output logic [DW_BITS-1:0] rd_dw
);
  logic               slt_lock;
  logic [DW_BITS-1:0] wmask;
  logic [DW_BITS-1:0] r_bus;

  assign slt_lock = sec_express && !SLT_WRITABLE;
  assign wmask    = slt_lock ? 32'h00FF_FFFF : 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (rst)     r_bus <= '0;
    else if (we) r_bus <= lane_merge(r_bus, wdata, be, wmask);
  end

  assign rd_dw = slt_lock ? {8'h00, r_bus[23:0]} : r_bus;
endmodule

// File: rtl/p2p_win_regs.sv
`timescale 1ns/1ps
module p2p_win_regs
  import p2p_hdr_pkg::*;
#(
  parameter bit IO32 = 1'b1,
  parameter bit PF64 = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fwd_off,
  input  logic [DW_BITS-1:0] wdata,
  input  logic [LANES-1:0]   be,
  input  logic               we_iosec,
  input  logic               we_mem,
  input  logic               we_pf,
  input  logic               we_pfbu,
  input  logic               we_pflu,
  input  logic               we_iou,
  output logic [DW_BITS-1:0] rd_iosec,
  output logic [DW_BITS-1:0] rd_mem,
  output logic [DW_BITS-1:0] rd_pf,
  output logic [DW_BITS-1:0] rd_pfbu,
  output logic [DW_BITS-1:0] rd_pflu,
  output logic [DW_BITS-1:0] rd_iou,
  output logic [31:0]        io_base,
  output logic [31:0]        io_limit,
  output logic [31:0]        mem_base,
  output logic [31:0]        mem_limit,
  output logic [63:0]        pf_base,
  output logic [63:0]        pf_limit
);
  localparam logic [3:0]  IO_TYPE = IO32 ? 4'h1 : 4'h0;
  localparam logic [3:0]  PF_TYPE = PF64 ? 4'h1 : 4'h0;
  localparam logic [31:0] M_IOSEC = 32'h0000_F0F0;
  localparam logic [31:0] M_RANGE = 32'hFFF0_FFF0;
  localparam logic [31:0] M_PFUP  = PF64 ? 32'hFFFF_FFFF : 32'h0;
  localparam logic [31:0] M_IOUP  = IO32 ? 32'hFFFF_FFFF : 32'h0;
  // forwarding-off reset images: base address bits ones, limit bits zero
  localparam logic [31:0] OFF_IOSEC = 32'h0000_00F0;
  localparam logic [31:0] OFF_RANGE = 32'h0000_FFF0;

  logic [31:0] r_iosec, r_mem, r_pf, r_pfbu, r_pflu, r_iou;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_iosec <= fwd_off ? OFF_IOSEC : '0;
      r_mem   <= fwd_off ? OFF_RANGE : '0;
      r_pf    <= fwd_off ? OFF_RANGE : '0;
      r_pfbu  <= '0;
      r_pflu  <= '0;
      r_iou   <= '0;
    end else begin
      if (we_iosec) r_iosec <= lane_merge(r_iosec, wdata, be, M_IOSEC);
      if (we_mem)   r_mem   <= lane_merge(r_mem,   wdata, be, M_RANGE);
      if (we_pf)    r_pf    <= lane_merge(r_pf,    wdata, be, M_RANGE);
      if (we_pfbu)  r_pfbu  <= lane_merge(r_pfbu,  wdata, be, M_PFUP);
      if (we_pflu)  r_pflu  <= lane_merge(r_pflu,  wdata, be, M_PFUP);
      if (we_iou)   r_iou   <= lane_merge(r_iou,   wdata, be, M_IOUP);
    end
  end

  assign rd_iosec = {STAT_CAPS, r_iosec[15:12], IO_TYPE, r_iosec[7:4], IO_TYPE};
  assign rd_mem   = r_mem;
  assign rd_pf    = {r_pf[31:20], PF_TYPE, r_pf[15:4], PF_TYPE};
  assign rd_pfbu  = r_pfbu;
  assign rd_pflu  = r_pflu;
  assign rd_iou   = r_iou;

  assign io_base   = {r_iou[15:0],  r_iosec[7:4],   12'h000};
  assign io_limit  = {r_iou[31:16], r_iosec[15:12], 12'hFFF};
  assign mem_base  = {r_mem[15:4],  20'h00000};
  assign mem_limit = {r_mem[31:20], 20'hFFFFF};
  assign pf_base   = {r_pfbu, r_pf[15:4],  20'h00000};
  assign pf_limit  = {r_pflu, r_pf[31:20], 20'hFFFFF};
endmodule

// File: rtl/p2p_ctl_regs.sv
`timescale 1ns/1ps
module p2p_ctl_regs
  import p2p_hdr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [DW_BITS-1:0] wdata,
  input  logic [LANES-1:0]   be,
  input  logic               we_cmd,
  input  logic               we_bctl,
  output logic [DW_BITS-1:0] rd_cmd,
  output logic [DW_BITS-1:0] rd_bctl,
  output logic [15:0]        cmd,
  output logic [15:0]        bctl,
  output logic               sbr_pulse
);
  localparam logic [31:0] M_CMD  = 32'h0000_0547;
  localparam logic [31:0] M_BCTL = 32'h007F_0000;

  logic [31:0] cmd_nxt, bctl_nxt;
  logic        sbr_rise;

  assign cmd_nxt  = lane_merge({16'h0, cmd},  wdata, be, M_CMD);
  assign bctl_nxt = lane_merge({bctl, 16'h0}, wdata, be, M_BCTL);
  assign sbr_rise = we_bctl && !bctl[SBR_BIT] && bctl_nxt[16+SBR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd       <= '0;
      bctl      <= '0;
      sbr_pulse <= 1'b0;
    end else begin
      if (we_cmd)  cmd  <= cmd_nxt[15:0];
      if (we_bctl) bctl <= bctl_nxt[31:16];
      sbr_pulse <= sbr_rise;
    end
  end

  assign rd_cmd  = {STAT_CAPS, cmd};
  assign rd_bctl = {bctl, 16'h0000};
endmodule

// File: rtl/p2p_hdr_regs.sv
`timescale 1ns/1ps
module p2p_hdr_regs
  import p2p_hdr_pkg::*;
#(
  parameter int         ADDR_W       = 6,
  parameter bit         IO32         = 1'b1,
  parameter bit         PF64         = 1'b1,
  parameter bit         MULTI_FN     = 1'b0,
  parameter logic [7:0] REV          = 8'h02,
  parameter bit         SLT_WRITABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_fwd_off,
  input  logic              sec_express,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic              cmd_io_en,
  output logic              cmd_mem_en,
  output logic [15:0]       bridge_ctl,
  output logic [31:0]       io_base,
  output logic [31:0]       io_limit,
  output logic [31:0]       mem_base,
  output logic [31:0]       mem_limit,
  output logic [63:0]       pf_base,
  output logic [63:0]       pf_limit,
  output logic              sec_bus_rst
);
  localparam logic [31:0] DW_CLASS = {CLASS_P2P, REV};
  localparam logic [31:0] DW_HDR   = {8'h00, MULTI_FN, 7'h01, 16'h0000};

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ix);
    return a == ADDR_W'(ix);
  endfunction

  logic we_cmd, we_bus, we_iosec, we_mem, we_pf, we_pfbu, we_pflu, we_iou, we_bctl;
  assign we_cmd   = wr_en && hit(addr, IX_CMD);
  assign we_bus   = wr_en && hit(addr, IX_BUS);
  assign we_iosec = wr_en && hit(addr, IX_IOSEC);
  assign we_mem   = wr_en && hit(addr, IX_MEM);
  assign we_pf    = wr_en && hit(addr, IX_PF);
  assign we_pfbu  = wr_en && hit(addr, IX_PFBU);
  assign we_pflu  = wr_en && hit(addr, IX_PFLU);
  assign we_iou   = wr_en && hit(addr, IX_IOU);
  assign we_bctl  = wr_en && hit(addr, IX_BCTL);

  logic [31:0] rd_bus, rd_iosec, rd_mem, rd_pf, rd_pfbu, rd_pflu, rd_iou, rd_cmd, rd_bctl;
  logic [15:0] cmd_w;

  p2p_bus_regs #(.SLT_WRITABLE(SLT_WRITABLE)) u_bus (
    .clk(clk), .rst(rst), .sec_express(sec_express),
    .we(we_bus), .wdata(wdata), .be(be), .rd_dw(rd_bus)
  );

  p2p_win_regs #(.IO32(IO32), .PF64(PF64)) u_win (
    .clk(clk), .rst(rst), .fwd_off(rst_fwd_off), .wdata(wdata), .be(be),
    .we_iosec(we_iosec), .we_mem(we_mem), .we_pf(we_pf),
    .we_pfbu(we_pfbu), .we_pflu(we_pflu), .we_iou(we_iou),
    .rd_iosec(rd_iosec), .rd_mem(rd_mem), .rd_pf(rd_pf),
    .rd_pfbu(rd_pfbu), .rd_pflu(rd_pflu), .rd_iou(rd_iou),
    .io_base(io_base), .io_limit(io_limit),
    .mem_base(mem_base), .mem_limit(mem_limit),
    .pf_base(pf_base), .pf_limit(pf_limit)
  );

  p2p_ctl_regs u_ctl (
    .clk(clk), .rst(rst), .wdata(wdata), .be(be),
    .we_cmd(we_cmd), .we_bctl(we_bctl),
    .rd_cmd(rd_cmd), .rd_bctl(rd_bctl),
    .cmd(cmd_w), .bctl(bridge_ctl), .sbr_pulse(sec_bus_rst)
  );

  assign cmd_io_en  = cmd_w[0];
  assign cmd_mem_en = cmd_w[1];

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if      (hit(addr, IX_CMD))   rd_mux = rd_cmd;
    else if (hit(addr, IX_CLASS)) rd_mux = DW_CLASS;
    else if (hit(addr, IX_HDR))   rd_mux = DW_HDR;
    else if (hit(addr, IX_BUS))   rd_mux = rd_bus;
    else if (hit(addr, IX_IOSEC)) rd_mux = rd_iosec;
    else if (hit(addr, IX_MEM))   rd_mux = rd_mem;
    else if (hit(addr, IX_PF))    rd_mux = rd_pf;
    else if (hit(addr, IX_PFBU))  rd_mux = rd_pfbu;
    else if (hit(addr, IX_PFLU))  rd_mux = rd_pflu;
    else if (hit(addr, IX_IOU))   rd_mux = rd_iou;
    else if (hit(addr, IX_BCTL))  rd_mux = rd_bctl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/p2p_hdr_sva.sv
`timescale 1ns/1ps
module p2p_hdr_sva (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic        rd_valid,
  input logic        sec_bus_rst,
  input logic [15:0] bridge_ctl,
  input logic [31:0] io_base,
  input logic [31:0] mem_base,
  input logic [31:0] mem_limit,
  input logic [63:0] pf_base,
  input logic [63:0] pf_limit
);
  // R7: pulse never lasts two cycles
  p_sbr_single_r7: assert property (@(posedge clk) disable iff (rst)
    sec_bus_rst |=> !sec_bus_rst);

  // R7: pulse only after bit 6 went from 0 to 1
  p_sbr_rise_r7: assert property (@(posedge clk) disable iff (rst)
    sec_bus_rst |-> (bridge_ctl[6] && !$past(bridge_ctl[6])));

  // R9: read data valid one cycle after request
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R5: windows change only through writes
  p_windows_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(io_base) && $stable(mem_base) && $stable(mem_limit)
                && $stable(pf_base) && $stable(pf_limit)));

  // R7: bridge control changes only through writes
  p_bctl_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(bridge_ctl));
endmodule

bind p2p_hdr_regs p2p_hdr_sva u_sva (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_valid(rd_valid),
  .sec_bus_rst(sec_bus_rst), .bridge_ctl(bridge_ctl), .io_base(io_base),
  .mem_base(mem_base), .mem_limit(mem_limit), .pf_base(pf_base), .pf_limit(pf_limit)
);

// File: tb/tb_p2p_hdr_regs.sv
`timescale 1ns/1ps
module tb_p2p_hdr_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_fwd_off = 1'b0;
  logic        sec_express = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;
  logic        rd_valid, cmd_io_en, cmd_mem_en, sec_bus_rst;
  logic [15:0] bridge_ctl;
  logic [31:0] io_base, io_limit, mem_base, mem_limit;
  logic [63:0] pf_base, pf_limit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] sh [0:15];

  always #10 clk = ~clk;   // 50 MHz

  p2p_hdr_regs dut (
    .clk(clk), .rst(rst), .rst_fwd_off(rst_fwd_off), .sec_express(sec_express),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .be(be),
    .rdata(rdata), .rd_valid(rd_valid), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
    .bridge_ctl(bridge_ctl), .io_base(io_base), .io_limit(io_limit),
    .mem_base(mem_base), .mem_limit(mem_limit), .pf_base(pf_base), .pf_limit(pf_limit),
    .sec_bus_rst(sec_bus_rst)
  );

  function automatic logic [31:0] wmask(input int ix);
    case (ix)
      1:          return 32'h0000_0547;
      6:          return sec_express ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
      7:          return 32'h0000_F0F0;
      8, 9:       return 32'hFFF0_FFF0;
      10, 11, 12: return 32'hFFFF_FFFF;
      15:         return 32'h007F_0000;
      default:    return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] cval(input int ix);
    case (ix)
      1:       return 32'h00A0_0000;
      2:       return 32'h0604_0002;
      3:       return 32'h0001_0000;
      7:       return 32'h00A0_0101;
      9:       return 32'h0001_0001;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int ix);
    logic [31:0] v;
    if (ix > 15) return 32'h0;
    v = sh[ix] | cval(ix);
    if (ix == 6 && sec_express) v[31:24] = 8'h00;
    return v;
  endfunction

  function automatic string req_of(input int ix);
    case (ix)
      2, 3:                 return "R4";
      6:                    return "R8";
      7, 8, 9, 10, 11, 12:  return "R6";
      1, 15:                return "R10";
      default:              return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset(input bit off);
    for (int i = 0; i < 16; i++) sh[i] = 32'h0;
    if (off) begin
      sh[7] = 32'h0000_00F0;
      sh[8] = 32'h0000_FFF0;
      sh[9] = 32'h0000_FFF0;
    end
  endtask

  task automatic chk_win();
    chk("R5", "io_base",   {32'h0, io_base},   {32'h0, sh[12][15:0], sh[7][7:4], 12'h000});
    chk("R5", "io_limit",  {32'h0, io_limit},  {32'h0, sh[12][31:16], sh[7][15:12], 12'hFFF});
    chk("R5", "mem_base",  {32'h0, mem_base},  {32'h0, sh[8][15:4], 20'h00000});
    chk("R5", "mem_limit", {32'h0, mem_limit}, {32'h0, sh[8][31:20], 20'hFFFFF});
    chk("R5", "pf_base",   pf_base,            {sh[10], sh[9][15:4], 20'h00000});
    chk("R5", "pf_limit",  pf_limit,           {sh[11], sh[9][31:20], 20'hFFFFF});
    chk("R10", "cmd_io_en",  {63'h0, cmd_io_en},  {63'h0, sh[1][0]});
    chk("R10", "cmd_mem_en", {63'h0, cmd_mem_en}, {63'h0, sh[1][1]});
    chk("R10", "bridge_ctl", {48'h0, bridge_ctl}, {48'h0, sh[15][31:16]});
  endtask

  task automatic do_reset(input bit off);
    @(negedge clk);
    rst = 1'b1; rst_fwd_off = off;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; rst_fwd_off = 1'b0;
    model_reset(off);
    chk(off ? "R2" : "R1", "sbr after reset", {63'h0, sec_bus_rst}, 64'h0);
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] b);
    logic old6;
    logic exp_p;
    logic [31:0] m;
    old6 = sh[15][22];
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = d; be = b;
    if (a < 16) begin
      for (int i = 0; i < 4; i++) m[i*8 +: 8] = b[i] ? 8'hFF : 8'h00;
      m = m & wmask(a);
      sh[a] = (sh[a] & ~m) | (d & m);   // R3 lane model
    end
    exp_p = (a == 15) && !old6 && sh[15][22];
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7", "sbr pulse", {63'h0, sec_bus_rst}, {63'h0, exp_p});
    chk_win();
    @(negedge clk);
    chk("R7", "sbr one cycle", {63'h0, sec_bus_rst}, 64'h0);
  endtask

  task automatic do_read(input int a);
    @(negedge clk);
    rd_en = 1'b1; addr = 6'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9", "rd_valid", {63'h0, rd_valid}, 64'h1);
    chk(req_of(a), $sformatf("rdata[%0d]", a), {32'h0, rdata}, {32'h0, exp_read(a)});
    @(negedge clk);
    chk("R9", "rd_valid drop", {63'h0, rd_valid}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    model_reset(1'b0);

    // R1: normal reset
    do_reset(1'b0);
    chk("R1", "mem_base",  {32'h0, mem_base},  64'h0);
    chk("R1", "mem_limit", {32'h0, mem_limit}, 64'h000F_FFFF);
    chk("R1", "io_limit",  {32'h0, io_limit},  64'h0000_0FFF);
    chk_win();
    for (int i = 0; i < 16; i++) do_read(i);

    // R2: forwarding-off reset
    do_reset(1'b1);
    chk("R2", "io_base",  {32'h0, io_base},  64'h0000_F000);
    chk("R2", "io_limit", {32'h0, io_limit}, 64'h0000_0FFF);
    chk("R2", "mem_base", {32'h0, mem_base}, 64'hFFF0_0000);
    chk("R2", "mem_limit",{32'h0, mem_limit},64'h000F_FFFF);
    chk("R2", "pf_base",  pf_base,           64'h0000_0000_FFF0_0000);
    chk("R2", "pf_limit", pf_limit,          64'h0000_0000_000F_FFFF);
    do_read(8); do_read(9); do_read(10);

    // R4: read-only constants survive all-ones writes
    do_reset(1'b0);
    do_write(2, 32'hFFFF_FFFF, 4'hF);
    do_write(3, 32'hFFFF_FFFF, 4'hF);
    do_write(7, 32'hFFFF_FFFF, 4'hF);
    do_write(9, 32'hFFFF_FFFF, 4'hF);
    do_write(1, 32'hFFFF_FFFF, 4'hF);
    do_read(2); do_read(3); do_read(7); do_read(9);
    do_read(1);
    chk("R10", "cmd literal", {32'h0, rdata}, 64'h00A0_0547);

    // R3: partial byte enables
    do_write(6, 32'hAABB_CCDD, 4'b0101);
    do_read(6);
    chk("R3", "lane literal", {32'h0, rdata}, 64'h00BB_00DD);

    // R8: express locks latency byte
    sec_express = 1'b1;
    do_write(6, 32'h1122_3344, 4'hF);
    do_read(6);
    chk("R8", "latency locked", {56'h0, rdata[31:24]}, 64'h0);
    sec_express = 1'b0;
    do_write(6, 32'h5500_0000, 4'b1000);
    do_read(6);
    chk("R8", "latency writable", {56'h0, rdata[31:24]}, 64'h55);

    // R6: upper registers
    do_write(12, 32'h1234_ABCD, 4'hF);
    chk("R6", "io_base upper",  {48'h0, io_base[31:16]},  64'hABCD);
    chk("R6", "io_limit upper", {48'h0, io_limit[31:16]}, 64'h1234);
    do_write(10, 32'hCAFE_0001, 4'hF);
    do_write(11, 32'hCAFE_0002, 4'hF);
    chk("R6", "pf_base upper",  {32'h0, pf_base[63:32]},  64'hCAFE_0001);

    // R7: secondary bus reset edge
    do_write(15, 32'h0040_0000, 4'b1000);   // lane 2 masked: no pulse
    do_write(15, 32'h0040_0000, 4'b0100);   // rising: pulse
    do_write(15, 32'h0048_0000, 4'b0100);   // already set: no pulse, VGA bit set
    chk("R10", "vga bit", {63'h0, bridge_ctl[3]}, 64'h1);
    do_write(15, 32'h0000_0000, 4'b0100);
    do_write(15, 32'h0040_0000, 4'b1111);   // rising again

    // R9: unmapped index
    do_write(40, 32'hDEAD_BEEF, 4'hF);
    do_read(40);
    do_read(0);

    // Random phase
    for (int k = 0; k < 600; k++) begin
      int r;
      int a;
      if (k % 150 == 149) do_reset(1'($urandom % 2));
      if (k % 100 == 0) sec_express = 1'($urandom % 2);
      r = int'($urandom % 22);
      a = (r < 16) ? r : (r < 19 ? 15 : 16 + int'($urandom % 48));
      if ($urandom % 2) do_write(a, $urandom, 4'($urandom));
      else              do_read(a);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule